// File: doc/BRIEF.md
# Dictionary-Coded Transition-Saving Bus Link

This block joins a transmitting end and a receiving end across a wide external data bus where every line transition costs power. Both ends hold an identical small dictionary of recently carried words. When the transmitter is handed a word that its dictionary already holds, it does not drive the word. Instead it flips the one signalling line owned by the matching slot. The receiver sees which line flipped and delivers the word from its own copy of that slot.

When the word is absent, the transmitter places the full word on the data lines and flips a separate new-word line, so the receiver can tell a fresh word apart from an idle cycle. Both dictionaries then store the new word in the slot named by a round-robin fill pointer and advance that pointer. Because both ends make the same decision at the same point in the stream, their contents stay equal.

The top module instantiates both ends and exposes the bus lines between them, so the traffic on the lines can be observed.

Top module: `vc_bus_link`

## Requirements
- R1: While reset is held and on the first cycle after it, `bus_data`, `bus_hit` and `bus_new` are all zero, `out_valid` is 0, and every dictionary slot is invalid.
- R2: A word accepted with `in_valid`=1 that no valid slot holds is driven on `bus_data` one clock after acceptance. In the same cycle `bus_new` inverts and `bus_hit` keeps its value.
- R3: A word accepted that valid slot i holds inverts bit i of `bus_hit` one clock after acceptance and no other hit bit. `bus_data` and `bus_new` keep their values.
- R4: A cycle with `in_valid`=0 changes none of the bus lines and produces no delivered word.
- R5: Every accepted word appears on `out_data` with `out_valid`=1 exactly two clocks after acceptance, in acceptance order, with the same value.
- R6: A new word is written to the slot under the fill pointer, and the pointer then advances. The pointer starts at slot 0 after reset and wraps from slot K-1 back to slot 0, so the (K+1)-th new word replaces the first one.
- R7: No two valid slots ever hold the same word. If several slots were to match, the lowest index would be chosen.
- R8: The receiver's slot contents and valid flags equal the transmitter's from one clock earlier.
- R9: An invalid slot never produces a hit, even when its stored bits equal the word. After reset, sending the all-zero word is handled as a new word.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | A word is offered for transfer this cycle |
| in_data | input | W | Word to transfer |
| bus_data | output | W | Bus data lines (changed only for a new word) |
| bus_hit | output | K | Slot signalling lines, one per dictionary slot |
| bus_new | output | 1 | New-word line, inverts on every full-word transfer |
| out_valid | output | 1 | Receiver delivers a word this cycle |
| out_data | output | W | Word delivered by the receiver |

## Verification
The bus lines react one clock after a word is accepted, and the delivered word follows one clock after that. The bench therefore drives inputs on falling edges and compares on the next falling edges. It computes the expected line action (which hit bit flips, or a new-word flip) from its own model of slot contents and fill pointer. A scoreboard queue pairs each line change and each delivered word with the oldest pending expectation, so that a missing, extra or late event shows up as a mismatch. Idle gaps between words test that nothing moves on the lines when no word is offered.

// File: rtl/vc_pkg.sv
package vc_pkg;

    // Kind of action the transmitter takes for one cycle
    typedef enum logic [1:0] {
        XF_IDLE = 2'd0,
        XF_HIT  = 2'd1,
        XF_NEW  = 2'd2
    } xfer_kind_e;

    // Width of a slot index for a dictionary of n slots
    function automatic int idx_width(input int n);
        return (n > 1) ? $clog2(n) : 1;
    endfunction

endpackage

// File: rtl/vc_dict_store.sv
// Dictionary storage: slot contents, valid flags and round-robin fill pointer.
module vc_dict_store #(
    parameter int W = 16,
    parameter int K = 4
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           wr_en,
    input  logic [W-1:0]   wr_data,
    output logic [K*W-1:0] tab_ent,
    output logic [K-1:0]   tab_vld
);
    localparam int IW = vc_pkg::idx_width(K);
    localparam logic [IW-1:0] LAST = IW'(K - 1);

    typedef struct packed {
        logic [K-1:0][W-1:0] ent;
        logic [K-1:0]        vld;
        logic [IW-1:0]       ptr;
    } store_t;

    store_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (wr_en) begin
            st_d.ent[st_q.ptr] = wr_data;
            st_d.vld[st_q.ptr] = 1'b1;
            st_d.ptr = (st_q.ptr == LAST) ? '0 : st_q.ptr + 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign tab_ent = st_q.ent;
    assign tab_vld = st_q.vld;

endmodule

// File: rtl/vc_dict_match.sv
// Combinational lookup: lowest valid slot whose content equals the key.
module vc_dict_match #(
    parameter int W = 16,
    parameter int K = 4
) (
    input  logic [K*W-1:0] tab_ent,
    input  logic [K-1:0]   tab_vld,
    input  logic [W-1:0]   key,
    output logic           hit,
    output logic [vc_pkg::idx_width(K)-1:0] hit_idx
);
    localparam int IW = vc_pkg::idx_width(K);

    logic [K-1:0] eq;

    for (genvar g = 0; g < K; g++) begin : g_cmp
        assign eq[g] = tab_vld[g] && (tab_ent[g*W +: W] == key);
    end

    always_comb begin
        hit     = 1'b0;
        hit_idx = '0;
        for (int i = K - 1; i >= 0; i--) begin
            if (eq[i]) begin
                hit     = 1'b1;
                hit_idx = IW'(i);
            end
        end
    end

endmodule

// File: rtl/vc_tx.sv
// Transmitting end: decides per word between a slot-line flip and a full word.
module vc_tx #(
    parameter int W = 16,
    parameter int K = 4
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           in_valid,
    input  logic [W-1:0]   in_data,
    output logic [W-1:0]   bus_data,
    output logic [K-1:0]   bus_hit,
    output logic           bus_new,
    output logic [K*W-1:0] tab_ent,
    output logic [K-1:0]   tab_vld
);
    import vc_pkg::*;
    localparam int IW = idx_width(K);

    typedef struct packed {
        logic [W-1:0] data;
        logic [K-1:0] hit;
        logic         nw;
    } tx_t;

    tx_t           tx_d, tx_q;
    logic          lk_hit;
    logic [IW-1:0] lk_idx;
    xfer_kind_e    kind;

    vc_dict_match #(.W(W), .K(K)) u_match (
        .tab_ent (tab_ent),
        .tab_vld (tab_vld),
        .key     (in_data),
        .hit     (lk_hit),
        .hit_idx (lk_idx)
    );

    vc_dict_store #(.W(W), .K(K)) u_store (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (kind == XF_NEW),
        .wr_data (in_data),
        .tab_ent (tab_ent),
        .tab_vld (tab_vld)
    );

    always_comb begin
        if (!in_valid)   kind = XF_IDLE;
        else if (lk_hit) kind = XF_HIT;
        else             kind = XF_NEW;
    end

    always_comb begin
        tx_d = tx_q;
        case (kind)
            XF_HIT: tx_d.hit[lk_idx] = ~tx_q.hit[lk_idx];
            XF_NEW: begin
                tx_d.data = in_data;
                tx_d.nw   = ~tx_q.nw;
            end
            default: ;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            tx_q <= '0;
        end else begin
            tx_q <= tx_d;
        end
    end

    assign bus_data = tx_q.data;
    assign bus_hit  = tx_q.hit;
    assign bus_new  = tx_q.nw;

endmodule

// File: rtl/vc_rx.sv
// Receiving end: decodes line flips back into words using its own dictionary.
module vc_rx #(
    parameter int W = 16,
    parameter int K = 4
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic [W-1:0]   bus_data,
    input  logic [K-1:0]   bus_hit,
    input  logic           bus_new,
    output logic           out_valid,
    output logic [W-1:0]   out_data,
    output logic [K*W-1:0] tab_ent,
    output logic [K-1:0]   tab_vld
);
    typedef struct packed {
        logic [K-1:0] hit_seen;
        logic         new_seen;
        logic         vld;
        logic [W-1:0] data;
    } rx_t;

    rx_t          rx_d, rx_q;
    logic [K-1:0] flip;
    logic         new_flip;

    assign flip     = bus_hit ^ rx_q.hit_seen;
    assign new_flip = bus_new ^ rx_q.new_seen;

    vc_dict_store #(.W(W), .K(K)) u_store (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (new_flip),
        .wr_data (bus_data),
        .tab_ent (tab_ent),
        .tab_vld (tab_vld)
    );

    always_comb begin
        rx_d          = rx_q;
        rx_d.hit_seen = bus_hit;
        rx_d.new_seen = bus_new;
        rx_d.vld      = 1'b0;
        if (new_flip) begin
            rx_d.vld  = 1'b1;
            rx_d.data = bus_data;
        end else begin
            for (int i = K - 1; i >= 0; i--) begin
                if (flip[i]) begin
                    rx_d.vld  = 1'b1;
                    rx_d.data = tab_ent[i*W +: W];
                end
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rx_q <= '0;
        end else begin
            rx_q <= rx_d;
        end
    end

    assign out_valid = rx_q.vld;
    assign out_data  = rx_q.data;

endmodule

// File: rtl/vc_bus_link.sv
// Top: transmitting end and receiving end joined by the encoded bus.
module vc_bus_link #(
    parameter int W = 16,
    parameter int K = 4
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         in_valid,
    input  logic [W-1:0] in_data,
    output logic [W-1:0] bus_data,
    output logic [K-1:0] bus_hit,
    output logic         bus_new,
    output logic         out_valid,
    output logic [W-1:0] out_data
);
    logic [K*W-1:0] tx_ent, rx_ent;
    logic [K-1:0]   tx_vld, rx_vld;

    vc_tx #(.W(W), .K(K)) u_tx (
        .clk      (clk),
        .rst_n    (rst_n),
        .in_valid (in_valid),
        .in_data  (in_data),
        .bus_data (bus_data),
        .bus_hit  (bus_hit),
        .bus_new  (bus_new),
        .tab_ent  (tx_ent),
        .tab_vld  (tx_vld)
    );

    vc_rx #(.W(W), .K(K)) u_rx (
        .clk       (clk),
        .rst_n     (rst_n),
        .bus_data  (bus_data),
        .bus_hit   (bus_hit),
        .bus_new   (bus_new),
        .out_valid (out_valid),
        .out_data  (out_data),
        .tab_ent   (rx_ent),
        .tab_vld   (rx_vld)
    );

endmodule

// File: rtl/vc_bus_link_chk.sv
// Property checker attached to the top module.
module vc_bus_link_chk #(
    parameter int W = 16,
    parameter int K = 4
) (
    input logic           clk,
    input logic           rst_n,
    input logic           in_valid,
    input logic [W-1:0]   bus_data,
    input logic [K-1:0]   bus_hit,
    input logic           bus_new,
    input logic           out_valid,
    input logic [K*W-1:0] tx_ent,
    input logic [K-1:0]   tx_vld,
    input logic [K*W-1:0] rx_ent,
    input logic [K-1:0]   rx_vld
);
    logic acc_q1, acc_q2;
    logic dup;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            acc_q1 <= 1'b0;
            acc_q2 <= 1'b0;
        end else begin
            acc_q1 <= in_valid;
            acc_q2 <= acc_q1;
        end
    end

    always_comb begin
        dup = 1'b0;
        for (int i = 0; i < K; i++) begin
            for (int j = i + 1; j < K; j++) begin
                if (tx_vld[i] && tx_vld[j] && tx_ent[i*W +: W] == tx_ent[j*W +: W])
                    dup = 1'b1;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            AST_RESET_QUIET: assert (bus_hit == '0 && !bus_new && tx_vld == '0); // R1
        end
    end

    AST_ONE_HIT_LINE: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(bus_hit ^ $past(bus_hit))); // R3

    AST_HIT_KEEPS_DATA: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_hit != $past(bus_hit)) |-> ($stable(bus_data) && $stable(bus_new))); // R3

    AST_DATA_ONLY_ON_NEW: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(bus_data) |-> !$stable(bus_new)); // R2

    AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |=> ($stable(bus_data) && $stable(bus_hit) && $stable(bus_new))); // R4

    AST_DELIVERY_SLOT: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid == acc_q2); // R5

    AST_NO_DUP_SLOT: assert property (@(posedge clk) disable iff (!rst_n)
        !dup); // R7

    AST_MIRROR_TABLE: assert property (@(posedge clk) disable iff (!rst_n)
        (rx_ent == $past(tx_ent)) && (rx_vld == $past(tx_vld))); // R8

endmodule

bind vc_bus_link vc_bus_link_chk #(.W(W), .K(K)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .in_valid  (in_valid),
    .bus_data  (bus_data),
    .bus_hit   (bus_hit),
    .bus_new   (bus_new),
    .out_valid (out_valid),
    .tx_ent    (tx_ent),
    .tx_vld    (tx_vld),
    .rx_ent    (rx_ent),
    .rx_vld    (rx_vld)
);

// File: tb/sim_vc_bus_link.sv
`timescale 1ns/1ps
module sim_vc_bus_link;
    localparam int W = 16;
    localparam int K = 4;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         in_valid = 1'b0;
    logic [W-1:0] in_data = '0;
    logic [W-1:0] bus_data;
    logic [K-1:0] bus_hit;
    logic         bus_new;
    logic         out_valid;
    logic [W-1:0] out_data;

    always #2.5 clk = ~clk;

    vc_bus_link #(.W(W), .K(K)) u0 (
        .clk       (clk),
        .rst_n     (rst_n),
        .in_valid  (in_valid),
        .in_data   (in_data),
        .bus_data  (bus_data),
        .bus_hit   (bus_hit),
        .bus_new   (bus_new),
        .out_valid (out_valid),
        .out_data  (out_data)
    );

    typedef struct {
        int           slot;   // -1 for a new word
        logic [W-1:0] word;
        string        tag;
    } exp_t;

    exp_t         bus_q[$];
    exp_t         out_q[$];
    int           n_chk = 0;
    int           n_bad = 0;
    bit           mon_on = 0;

    // Reference model of the dictionary, built from the requirements
    logic [W-1:0] m_ent[K];
    bit           m_vld[K];
    int           m_ptr = 0;

    task automatic check(input bit ok, input string tag, input string what,
                         input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s %s: actual %h expected %h", tag, what, act, exp);
        end
    endtask

    task automatic send(input logic [W-1:0] w, input string tag_over);
        exp_t e;
        int   s = -1;
        for (int i = K - 1; i >= 0; i--)
            if (m_vld[i] && m_ent[i] == w) s = i;
        if (s < 0) begin
            m_ent[m_ptr] = w;
            m_vld[m_ptr] = 1;
            m_ptr = (m_ptr == K - 1) ? 0 : m_ptr + 1;
        end
        e.slot = s;
        e.word = w;
        e.tag  = (tag_over != "") ? tag_over : ((s < 0) ? "R2" : "R3");
        bus_q.push_back(e);
        e.tag = "R5";
        out_q.push_back(e);
        @(negedge clk);
        in_valid = 1'b1;
        in_data  = w;
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            in_valid = 1'b0;
            in_data  = ~in_data;   // changing data while idle must not matter (R4)
        end
    endtask

    // Monitor: compares line activity and delivered words against the queues
    initial begin : monitor
        logic [K-1:0] p_hit;
        logic         p_new;
        logic [W-1:0] p_dat;
        exp_t         e;
        wait (mon_on);
        p_hit = bus_hit; p_new = bus_new; p_dat = bus_data;
        forever begin
            @(negedge clk);
            if (bus_hit != p_hit || bus_new != p_new || bus_data != p_dat) begin
                if (bus_q.size() == 0) begin
                    check(0, "R4", "line change with nothing offered", {bus_hit, bus_new}, {p_hit, p_new});
                end else begin
                    e = bus_q.pop_front();
                    if (e.slot < 0) begin
                        check(bus_new != p_new, e.tag, "new-word line flip", bus_new, ~p_new);
                        check(bus_hit == p_hit, e.tag, "hit lines kept", bus_hit, p_hit);
                        check(bus_data == e.word, e.tag, "data lines", bus_data, e.word);
                    end else begin
                        check((bus_hit ^ p_hit) == K'(1 << e.slot), e.tag, "hit line flip",
                              bus_hit ^ p_hit, K'(1 << e.slot));
                        check(bus_new == p_new && bus_data == p_dat, e.tag, "data/new lines kept",
                              bus_data, p_dat);
                    end
                end
            end
            if (out_valid) begin
                if (out_q.size() == 0) begin
                    check(0, "R5", "unexpected delivered word", out_data, 0);
                end else begin
                    e = out_q.pop_front();
                    check(out_data == e.word, "R5", "delivered word", out_data, e.word);
                end
            end
            p_hit = bus_hit; p_new = bus_new; p_dat = bus_data;
        end
    end

    bit timed_out = 0;

    initial begin : driver
        logic [15:0] lf = 16'hACE1;
        for (int i = 0; i < K; i++) begin m_ent[i] = '0; m_vld[i] = 0; end
        repeat (4) @(negedge clk);
        check(bus_hit == '0 && !bus_new && bus_data == '0, "R1", "bus lines in reset",
              {bus_data, bus_hit, bus_new}, 0);
        check(!out_valid, "R1", "no delivery in reset", out_valid, 0);
        rst_n = 1'b1;
        @(negedge clk);
        check(bus_hit == '0 && !bus_new && !out_valid, "R1", "quiet after reset",
              {bus_hit, bus_new, out_valid}, 0);
        mon_on = 1;

        send(16'h0000, "R9");            // zero matches invalid slots' bits: must be new
        send(16'h1111, "R6");            // slot 1
        send(16'h0000, "R3");            // hit slot 0
        send(16'h1111, "R7");            // hit slot 1, same line every time
        idle(3);
        send(16'h2222, "R6");            // slot 2
        send(16'h3333, "R6");            // slot 3
        send(16'h4444, "R6");            // wraps, replaces slot 0
        send(16'h0000, "R6");            // evicted: new, replaces slot 1
        send(16'h4444, "R6");            // hit slot 0
        send(16'h0000, "R6");            // hit slot 1
        send(16'h1111, "R6");            // evicted: new, slot 2
        idle(2);
        for (int n = 0; n < 300; n++) begin
            lf = {lf[14:0], lf[15] ^ lf[13] ^ lf[12] ^ lf[10]};
            send(W'((lf % 7) * 16'h1357), "");
            if (lf[3] && lf[8]) idle(int'(lf[1:0]) + 1);
        end
        idle(4);
        fork
            begin
                wait (bus_q.size() == 0 && out_q.size() == 0);
            end
            begin
                repeat (1000) @(negedge clk);
                timed_out = 1;
            end
        join_any
        disable fork;
        check(bus_q.size() == 0, "R2", "pending line events", bus_q.size(), 0);
        check(out_q.size() == 0, "R5", "pending deliveries", out_q.size(), 0);
        finish_run();
    end

    initial begin : watchdog
        repeat (20000) @(posedge clk);
        timed_out = 1;
        finish_run();
    end

    task automatic finish_run();
        if (timed_out) check(0, "R5", "watchdog expired", 1, 0);
        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
    endtask

endmodule